// File: doc/BRIEF.md
# Adaptive Thermal Throttle Controller

This controller watches a digital thermal margin from an on-die sensor. When the margin reads zero, the die has reached its fixed calibrated trip point. The controller then lowers power in escalating stages.

The first stage lowers the core frequency ratio one notch at a time. Each notch stops the core clock for a short window, changes the ratio, restarts the clock, and then lowers the supply voltage code to suit the new ratio. After each notch the controller waits a long recheck interval and reads the margin again. Once the ratio has reached its configured floor and the part is still hot, the controller adds on/off gating of the core clock at a fixed duty cycle. When the margin is nonzero again at a recheck, gating stops. The ratio and voltage then climb back one notch per interval until they reach the requested ratio again. The hot indicator follows the margin throughout.

The trip point cannot be configured. Snoop and interrupt signals cross the block unchanged whether or not throttling is active. The clock-stop window and the recheck interval are counted in reference clock cycles and set by parameters. The PLL and the voltage regulator are represented only by the strobe and code outputs.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: `hotN` goes low one clock edge after `margin` is sampled at zero. It goes high one edge after `margin` is sampled nonzero. No other margin value trips the block.
- R2: With a nonzero margin and no throttling in progress, `ratioOut` follows `curRatio` one cycle later. In that state `vidOut` equals `VID_BASE + (ratio - MIN_RATIO) * VID_STEP`, `clkStop` is low, `modEn` is low and `coreClkEn` is high.
- R3: A downward step starts one edge after the hot flag is seen at a decision point. At that edge `clkStop` rises and `ratioOut` drops by exactly one. `clkStop` then stays high for exactly `STOP_CYC` cycles, and `coreClkEn` is low for that whole window.
- R4: During a downward step `vidOut` keeps its old code while `clkStop` is high. It changes to the code for the new ratio at the edge where `clkStop` falls.
- R5: The next decision comes `RECHECK_CYC` cycles after `clkStop` falls. If the margin is still zero, another step starts then, so successive steps begin `STOP_CYC + RECHECK_CYC` cycles apart.
- R6: `ratioOut` never drops below `MIN_RATIO`. If the block is still hot at a decision point with the ratio at `MIN_RATIO`, `modEn` rises at that edge. From then on, counting from that edge, `coreClkEn` is high for the first `MOD_ON` of every `MOD_PERIOD` cycles.
- R7: If the margin is nonzero at a decision point, `modEn` falls at that edge. If the ratio is below `curRatio`, the ratio rises by one at that same edge and `vidOut` takes the code for the higher ratio at that edge too. `clkStop` is then high for `STOP_CYC` cycles. Further rising steps follow every `STOP_CYC + RECHECK_CYC` cycles until the ratio equals `curRatio`.
- R8: `snoopOut` and `irqOut` always equal `snoopIn` and `irqIn`.
- R9: While reset is applied, `ratioOut` is `MIN_RATIO`, `vidOut` is `VID_BASE`, `clkStop` and `modEn` are low, and `coreClkEn` and `hotN` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| margin | input | MW | Thermal margin reading; zero means at or above trip |
| curRatio | input | RW | Requested core frequency ratio |
| snoopIn | input | 1 | Snoop request from the fabric |
| irqIn | input | IW | Interrupt lines |
| clkStop | output | 1 | High while the core clock is stopped for a ratio change |
| ratioOut | output | RW | Ratio applied to the core clock generator |
| vidOut | output | VW | Supply voltage code sent to the regulator |
| modEn | output | 1 | Clock modulation engaged |
| coreClkEn | output | 1 | Core clock enable after stop and modulation gating |
| hotN | output | 1 | Active-low hot indicator |
| snoopOut | output | 1 | Snoop request passed to the core |
| irqOut | output | IW | Interrupt lines passed to the core |

## Verification
A wrong state or timer value inside the controller shows at the ports as a `clkStop` pulse of the wrong width, or as steps spaced at the wrong interval. Either error appears within one step period, `STOP_CYC + RECHECK_CYC` cycles. A ratio or voltage register that falls out of step with the sequence shows at once as a `ratioOut` or `vidOut` value that does not match the arithmetic schedule. This is checked every cycle of the descent, of the modulation phase and of the climb back. A wrong duty counter shows within one `MOD_PERIOD` as a wrong `coreClkEn` pattern.

// File: rtl/tt_pkg.sv
package tt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STOP,
    ST_WAIT
  } ttState_t;

  // strobes from control to datapath, at most one ratio action per cycle
  typedef struct packed {
    logic ratioLoad;
    logic ratioDec;
    logic ratioInc;
    logic vidLoad;
    logic tmrStop;
    logic tmrWait;
    logic modOn;
    logic modOff;
  } ttStrobe_t;

endpackage

// File: rtl/tt_datapath.sv
module tt_datapath
  import tt_pkg::*;
#(
  parameter int RW          = 6,
  parameter int VW          = 8,
  parameter int MIN_RATIO   = 8,
  parameter int VID_BASE    = 40,
  parameter int VID_STEP    = 4,
  parameter int STOP_CYC    = 100,
  parameter int RECHECK_CYC = 50000,
  parameter int MOD_PERIOD  = 16,
  parameter int MOD_ON      = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  ttStrobe_t       stb,
  input  logic [RW-1:0]   curRatio,
  output logic [RW-1:0]   ratioQ,
  output logic [VW-1:0]   vidQ,
  output logic            tmrZero,
  output logic [31:0]     tmrVal,
  output logic            atMin,
  output logic            atTarget,
  output logic            modEnQ,
  output logic            dutyOn
);

  localparam int TMAX = (STOP_CYC > RECHECK_CYC) ? STOP_CYC : RECHECK_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int DW   = (MOD_PERIOD > 1) ? $clog2(MOD_PERIOD) : 1;

  logic [TW-1:0] tmrQ;
  logic [DW-1:0] dutyQ;

  // voltage code as a linear function of the ratio, floored at the minimum
  function automatic logic [VW-1:0] vidOf(input logic [RW-1:0] r);
    if (int'(r) <= MIN_RATIO) return VW'(VID_BASE);
    return VW'(VID_BASE + (int'(r) - MIN_RATIO) * VID_STEP);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratioQ <= RW'(MIN_RATIO);
      vidQ   <= VW'(VID_BASE);
    end else begin
      if (stb.ratioLoad) begin
        ratioQ <= curRatio;
        vidQ   <= vidOf(curRatio);
      end else if (stb.ratioDec) begin
        ratioQ <= ratioQ - 1'b1;
      end else if (stb.ratioInc) begin
        ratioQ <= ratioQ + 1'b1;
        vidQ   <= vidOf(ratioQ + 1'b1);
      end else if (stb.vidLoad) begin
        vidQ   <= vidOf(ratioQ);
      end
    end
  end

  // one shared down-counter serves the stop window and the recheck interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrQ <= '0;
    end else if (stb.tmrStop) begin
      tmrQ <= TW'(STOP_CYC - 1);
    end else if (stb.tmrWait) begin
      tmrQ <= TW'(RECHECK_CYC - 1);
    end else if (tmrQ != '0) begin
      tmrQ <= tmrQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modEnQ <= 1'b0;
      dutyQ  <= '0;
    end else begin
      if (stb.modOn) begin
        modEnQ <= 1'b1;
      end else if (stb.modOff) begin
        modEnQ <= 1'b0;
      end
      if (!modEnQ || dutyQ == DW'(MOD_PERIOD - 1)) begin
        dutyQ <= '0;
      end else begin
        dutyQ <= dutyQ + 1'b1;
      end
    end
  end

  generate
    if (MOD_ON >= MOD_PERIOD) begin : g_dutyFull
      assign dutyOn = 1'b1;
    end else begin : g_dutyCmp
      assign dutyOn = (dutyQ < DW'(MOD_ON));
    end
  endgenerate

  assign tmrZero  = (tmrQ == '0);
  assign tmrVal   = 32'(tmrQ);
  assign atMin    = (int'(ratioQ) <= MIN_RATIO);
  assign atTarget = (ratioQ >= curRatio);

  AST_DUTY_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    modEnQ |-> (int'(dutyQ) < MOD_PERIOD)) else $error("duty counter out of range"); // R6
  AST_NO_DEC_AT_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    stb.ratioDec |-> (int'(ratioQ) > MIN_RATIO)) else $error("ratio decrement at floor"); // R6
  AST_INC_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    stb.ratioInc |-> (ratioQ < curRatio)) else $error("ratio raised past target"); // R7

endmodule

// File: rtl/tt_control.sv
module tt_control
  import tt_pkg::*;
#(
  parameter int STOP_CYC = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        marginZero,
  input  logic        tmrZero,
  input  logic [31:0] tmrVal,
  input  logic        atMin,
  input  logic        atTarget,
  output ttStrobe_t   stb,
  output logic        clkStop,
  output logic        hotN
);

  ttState_t stateQ, stateNxt;
  logic     hotQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      hotQ   <= 1'b0;
    end else begin
      stateQ <= stateNxt;
      hotQ   <= marginZero;
    end
  end

  always_comb begin
    stb      = '0;
    stateNxt = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (hotQ) begin
          if (!atMin) begin
            stb.ratioDec = 1'b1;
            stb.tmrStop  = 1'b1;
            stateNxt     = ST_STOP;
          end else begin
            stb.modOn    = 1'b1;
            stb.tmrWait  = 1'b1;
            stateNxt     = ST_WAIT;
          end
        end else begin
          stb.ratioLoad = 1'b1;
        end
      end
      ST_STOP: begin
        if (tmrZero) begin
          stb.vidLoad = 1'b1;
          stb.tmrWait = 1'b1;
          stateNxt    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (tmrZero) begin
          if (hotQ) begin
            if (!atMin) begin
              stb.ratioDec = 1'b1;
              stb.tmrStop  = 1'b1;
              stateNxt     = ST_STOP;
            end else begin
              stb.modOn    = 1'b1;
              stb.tmrWait  = 1'b1;
            end
          end else begin
            stb.modOff = 1'b1;
            if (!atTarget) begin
              stb.ratioInc = 1'b1;
              stb.tmrStop  = 1'b1;
              stateNxt     = ST_STOP;
            end else begin
              stateNxt     = ST_IDLE;
            end
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign clkStop = (stateQ == ST_STOP);
  assign hotN    = ~hotQ;

  AST_STOP_WINDOW_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_STOP) |-> (tmrVal < STOP_CYC)) else $error("stop window overrun"); // R3
  AST_STOP_ENDS_IN_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_STOP && tmrZero) |=> (stateQ == ST_WAIT)) else $error("stop did not end"); // R5

endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
  import tt_pkg::*;
#(
  parameter int MW          = 8,
  parameter int RW          = 6,
  parameter int VW          = 8,
  parameter int IW          = 4,
  parameter int MIN_RATIO   = 8,
  parameter int VID_BASE    = 40,
  parameter int VID_STEP    = 4,
  parameter int STOP_CYC    = 100,
  parameter int RECHECK_CYC = 50000,
  parameter int MOD_PERIOD  = 16,
  parameter int MOD_ON      = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [MW-1:0] margin,
  input  logic [RW-1:0] curRatio,
  input  logic          snoopIn,
  input  logic [IW-1:0] irqIn,
  output logic          clkStop,
  output logic [RW-1:0] ratioOut,
  output logic [VW-1:0] vidOut,
  output logic          modEn,
  output logic          coreClkEn,
  output logic          hotN,
  output logic          snoopOut,
  output logic [IW-1:0] irqOut
);

  ttStrobe_t   stb;
  logic        tmrZero;
  logic [31:0] tmrVal;
  logic        atMin;
  logic        atTarget;
  logic        dutyOn;

  tt_control #(
    .STOP_CYC (STOP_CYC)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .marginZero (margin == '0),
    .tmrZero    (tmrZero),
    .tmrVal     (tmrVal),
    .atMin      (atMin),
    .atTarget   (atTarget),
    .stb        (stb),
    .clkStop    (clkStop),
    .hotN       (hotN)
  );

  tt_datapath #(
    .RW          (RW),
    .VW          (VW),
    .MIN_RATIO   (MIN_RATIO),
    .VID_BASE    (VID_BASE),
    .VID_STEP    (VID_STEP),
    .STOP_CYC    (STOP_CYC),
    .RECHECK_CYC (RECHECK_CYC),
    .MOD_PERIOD  (MOD_PERIOD),
    .MOD_ON      (MOD_ON)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .curRatio (curRatio),
    .ratioQ   (ratioOut),
    .vidQ     (vidOut),
    .tmrZero  (tmrZero),
    .tmrVal   (tmrVal),
    .atMin    (atMin),
    .atTarget (atTarget),
    .modEnQ   (modEn),
    .dutyOn   (dutyOn)
  );

  assign coreClkEn = ~clkStop & (~modEn | dutyOn);
  assign snoopOut  = snoopIn;
  assign irqOut    = irqIn;

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkStop) |-> (ratioOut == $past(ratioOut) - 1'b1 || ratioOut == $past(ratioOut) + 1'b1))
    else $error("ratio step not one"); // R3
  AST_VID_FROZEN_IN_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (clkStop && $past(clkStop)) |-> $stable(vidOut)) else $error("vid moved in stop"); // R4
  AST_MOD_AT_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    modEn |-> (int'(ratioOut) == MIN_RATIO)) else $error("modulation above floor"); // R6
  AST_NO_MOD_WHILE_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    clkStop |-> !modEn) else $error("modulation during stop"); // R7

endmodule

// File: tb/thermal_throttle_ctrl_bench.sv
module thermal_throttle_ctrl_bench;

  localparam int MW = 4, RW = 4, VW = 6, IW = 2;
  localparam int MINR = 4, VB = 10, VS = 3;
  localparam int S = 3, R = 7, P = 4, ON = 3;
  localparam int SR = S + R;

  logic          clk = 1'b0;
  logic          rstN;
  logic [MW-1:0] margin;
  logic [RW-1:0] curRatio;
  logic          snoopIn;
  logic [IW-1:0] irqIn;
  logic          clkStop, modEn, coreClkEn, hotN, snoopOut;
  logic [RW-1:0] ratioOut;
  logic [VW-1:0] vidOut;
  logic [IW-1:0] irqOut;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  thermal_throttle_ctrl #(
    .MW(MW), .RW(RW), .VW(VW), .IW(IW), .MIN_RATIO(MINR), .VID_BASE(VB),
    .VID_STEP(VS), .STOP_CYC(S), .RECHECK_CYC(R), .MOD_PERIOD(P), .MOD_ON(ON)
  ) u_thermal_throttle_ctrl (
    .clk(clk), .rstN(rstN), .margin(margin), .curRatio(curRatio),
    .snoopIn(snoopIn), .irqIn(irqIn), .clkStop(clkStop), .ratioOut(ratioOut),
    .vidOut(vidOut), .modEn(modEn), .coreClkEn(coreClkEn), .hotN(hotN),
    .snoopOut(snoopOut), .irqOut(irqOut)
  );

  function automatic int eVid(input int r);
    return VB + (r - MINR) * VS;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic expectOut(input string req, input int eR, input int eV, input int eS,
                           input int eM, input int eE, input int eH);
    check({req, " ratio"}, int'(ratioOut), eR);
    check({req, " vid"}, int'(vidOut), eV);
    check({req, " clkStop"}, int'(clkStop), eS);
    check({req, " modEn"}, int'(modEn), eM);
    check({req, " coreClkEn"}, int'(coreClkEn), eE);
    check({req, " hotN"}, int'(hotN), eH);
  endtask

  task automatic tick();
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  // watchdog: an expired run counts as a failure and still prints the summary
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, tm, k, ph, eR, eV, eS, eM, eE, found;
    rstN = 1'b0;
    margin = 4'd5;
    curRatio = RW'(MINR + 2);
    snoopIn = 1'b0;
    irqIn = '0;
    @(negedge clk);
    @(negedge clk);
    // R9: values held during reset
    expectOut("R9 reset", MINR, VB, 0, 0, 1, 1);
    rstN = 1'b1;

    // R2 / R1: every nonzero margin leaves the block idle and tracking
    for (int m = 1; m < (1 << MW); m++) begin
      margin = MW'(m);
      curRatio = RW'(MINR + (m % 5));
      tick();
      tick();
      expectOut("R2 R1 idle", MINR + (m % 5), eVid(MINR + (m % 5)), 0, 0, 1, 1);
    end

    for (int r0 = MINR; r0 <= MINR + 5; r0++) begin
      curRatio = RW'(r0);
      margin = 4'd9;
      tick();
      tick();
      expectOut("R2 settle", r0, eVid(r0), 0, 0, 1, 1);

      n = r0 - MINR;
      tm = 1 + n * SR;
      margin = '0;
      // t counts edges after the margin went to zero, starting at 0
      for (int t = 0; t <= tm + 2 * P + 1; t++) begin
        tick();
        if (t == 0) begin
          expectOut("R1 trip", r0, eVid(r0), 0, 0, 1, 0);
        end else begin
          k = (t - 1) / SR;
          ph = (t - 1) % SR;
          if (k < n) begin
            eS = (ph < S) ? 1 : 0;
            eR = r0 - k - 1;
            eV = (ph < S) ? eVid(r0 - k) : eVid(r0 - k - 1);
            expectOut("R3 R4 R5 descend", eR, eV, eS, 0, 1 - eS, 0);
          end else begin
            eE = (((t - tm) % P) < ON) ? 1 : 0;
            expectOut("R6 modulate", MINR, eVid(MINR), 0, 1, eE, 0);
          end
        end
        snoopIn = t[0];
        irqIn = IW'(t);
        #1;
        check("R8 snoop", int'(snoopOut), t % 2);
        check("R8 irq", int'(irqOut), t % 4);
      end

      margin = 4'd3;
      tick();
      check("R1 release hotN", int'(hotN), 1);
      found = 0;
      for (int w = 0; w < R + 3; w++) begin
        if (!modEn) begin
          found = 1;
          break;
        end
        tick();
      end
      check("R7 modulation stops", found, 1);

      // u counts edges after the decision that dropped modulation
      for (int u = 0; u <= n * SR + 3; u++) begin
        k = u / SR;
        ph = u % SR;
        if (k < n) begin
          eS = (ph < S) ? 1 : 0;
          expectOut("R7 restore", MINR + k + 1, eVid(MINR + k + 1), eS, 0, 1 - eS, 1);
        end else begin
          expectOut("R7 R2 restored", r0, eVid(r0), 0, 0, 1, 1);
        end
        tick();
      end
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule